// File: doc/BRIEF.md
# SCI Routing and Power-Management Lock Control

This block holds three configuration registers of a south-bridge style bridge: a power-management I/O base doubleword, an ACPI control byte, and a 16-bit power-management control word. It turns the three-bit interrupt-select field of the control byte into the IRQ number that the system control interrupt (SCI) is delivered on. It drives the SCI level onto that number. When software moves the SCI while the line is asserted, the old line is released for one cycle before the new one is raised.

The base register is published as an effective I/O base. The ACPI enable bit gates this base, and an alignment mask trims it. The control word carries a sticky SMI lock bit. Once that bit is set, it and bit 0 of the SMI enable register become read-only until reset. The block reports both write masks so that the owners of those registers can honour them. Configuration writes arrive one doubleword at a time, with byte enables, on a dword index.

Top module: `pm_sci_ctl`

## Requirements
- R1: Select field bits [2:0] of the ACPI control byte (dword index ACPI_IDX, byte 0) map codes 0, 1, 2, 4 and 5 to IRQ 9, 10, 11, 20 and 21 respectively.
- R2: Codes 3, 6 and 7 are reserved. A write that evaluates one of them leaves the SCI target unchanged and pulses sel_err high for the single cycle after the write.
- R3: If sci_level is high when a write selects a different legal target, then in the cycle after the write sci_level is low and sci_irq still shows the old target. In the cycle after that, sci_irq shows the new target and sci_level follows sci_req again. Reselecting the current target has no effect.
- R4: If sci_level is low, a write selecting a different legal target moves sci_irq in the cycle after the write.
- R5: pm_base equals the base dword ANDed with BASE_MASK (default 0x0000FF80) while bit 7 of the ACPI control byte is 1, and equals 0 while that bit is 0.
- R6: sci_level equals sci_req as sampled at the previous clock edge. It changes only when sci_req changes, except during an R3 retarget.
- R7: Writing 1 to bit 4 of the PM control word (dword index PMCON_IDX, bytes 0-1) locks that bit at 1 until reset, and clears bit 4 of pm_ctl_wmask.
- R8: smi_en_wmask0 is 1 until the lock bit of R7 is set, then stays 0 until reset.
- R9: A write re-evaluates the target and base only if it touches any byte of the base dword or byte 0 of the ACPI dword. Other writes, including an ACPI-dword write with be[0]=0, change nothing.
- R10: sci_apic is 1 exactly when sci_irq is 16 or more.
- R11: After reset: the ACPI byte is 0x00, the base dword is 0x00000001, sci_irq is 9, sci_level is 0, sel_err is 0, pm_ctl is 0, and both write masks are all ones.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_idx | input | ADDR_W | Dword index of the write |
| cfg_be | input | 4 | Byte enables of the write |
| cfg_wdata | input | 32 | Write data |
| sci_req | input | 1 | SCI request level from the PM logic |
| pm_base | output | 32 | Effective PM I/O base (0 when disabled) |
| sci_irq | output | 5 | Current SCI target IRQ number |
| sci_level | output | 1 | SCI level driven on sci_irq |
| sci_apic | output | 1 | Target belongs to the APIC-side range |
| sel_err | output | 1 | Reserved select code was evaluated |
| pm_ctl | output | 16 | PM control word |
| pm_ctl_wmask | output | 16 | Write mask of the PM control word |
| smi_en_wmask0 | output | 1 | Write enable of SMI enable bit 0 |

## Verification
On every cycle, the assertions check the following: the target is always one of the five legal IRQs, the target never moves while the line was high in the previous cycle, the line is high only after a high request, the base reads zero while ACPI is disabled, and both the lock and the SMI write-mask bit are sticky. The exact cycle sequence of a retarget needs the bench's scenarios, as do the reserved-code error pulse, the mapping of each code, the writes that must not hit, and the values after reset.

// File: rtl/pm_sci_pkg.sv
package pm_sci_pkg;
    localparam int IRQ_W   = 5;
    localparam int CODE_W  = 3;
    localparam int APIC_LO = 16;
    localparam int LOCK_BIT = 4;

    typedef struct packed {
        logic             legal;
        logic [IRQ_W-1:0] irq;
    } sel_t;

    function automatic sel_t sel_decode(input logic [CODE_W-1:0] code);
        sel_t r;
        r.legal = 1'b1;
        case (code)
            3'd0:    r.irq = IRQ_W'(9);
            3'd1:    r.irq = IRQ_W'(10);
            3'd2:    r.irq = IRQ_W'(11);
            3'd4:    r.irq = IRQ_W'(20);
            3'd5:    r.irq = IRQ_W'(21);
            default: begin
                r.legal = 1'b0;
                r.irq   = '0;
            end
        endcase
        return r;
    endfunction
endpackage

// File: rtl/pm_sci_decode.sv
module pm_sci_decode
    import pm_sci_pkg::*;
(
    input  logic [CODE_W-1:0] code,
    output logic              legal,
    output logic [IRQ_W-1:0]  irq
);
    sel_t s;
    always_comb begin
        s     = sel_decode(code);
        legal = s.legal;
        irq   = s.irq;
    end
endmodule

// File: rtl/pm_sci_router.sv
module pm_sci_router
    import pm_sci_pkg::*;
#(
    parameter logic [IRQ_W-1:0] RST_IRQ = IRQ_W'(9)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             eval,
    input  logic             legal,
    input  logic [IRQ_W-1:0] new_irq,
    input  logic             sci_req,
    output logic [IRQ_W-1:0] tgt,
    output logic             line,
    output logic             err
);
    typedef struct packed {
        logic [IRQ_W-1:0] tgt;
        logic [IRQ_W-1:0] ptgt;
        logic             pend;
        logic             line;
        logic             err;
    } rt_t;

    rt_t st_d, st_q;
    logic [IRQ_W-1:0] cur;

    always_comb begin
        cur       = st_q.pend ? st_q.ptgt : st_q.tgt;
        st_d      = st_q;
        st_d.tgt  = cur;
        st_d.pend = 1'b0;
        st_d.line = sci_req;
        st_d.err  = eval && !legal;
        if (eval && legal && (new_irq != cur)) begin
            if (st_q.line) begin
                // release the old pin for one cycle, raise the new one next
                st_d.pend = 1'b1;
                st_d.ptgt = new_irq;
                st_d.line = 1'b0;
            end else begin
                st_d.tgt = new_irq;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q      <= '0;
            st_q.tgt  <= RST_IRQ;
            st_q.ptgt <= RST_IRQ;
        end else begin
            st_q <= st_d;
        end
    end

    assign tgt  = st_q.tgt;
    assign line = st_q.line;
    assign err  = st_q.err;
endmodule

// File: rtl/pm_sci_lock.sv
module pm_sci_lock
    import pm_sci_pkg::*;
#(
    parameter int CTL_W = 16
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr,
    input  logic [CTL_W/8-1:0] be,
    input  logic [CTL_W-1:0]   wdata,
    output logic [CTL_W-1:0]   ctl,
    output logic [CTL_W-1:0]   wmask,
    output logic               smi_wm0
);
    localparam int NB = CTL_W / 8;

    typedef struct packed {
        logic [CTL_W-1:0] ctl;
    } lk_t;

    lk_t st_d, st_q;
    logic [CTL_W-1:0] merged;

    always_comb begin
        wmask           = '1;
        wmask[LOCK_BIT] = !st_q.ctl[LOCK_BIT];
        merged          = (st_q.ctl & ~wmask) | (wdata & wmask);
        st_d            = st_q;
        if (wr) begin
            for (int b = 0; b < NB; b++) begin
                if (be[b]) st_d.ctl[b*8 +: 8] = merged[b*8 +: 8];
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign ctl     = st_q.ctl;
    assign smi_wm0 = !st_q.ctl[LOCK_BIT];
endmodule

// File: rtl/pm_sci_ctl.sv
module pm_sci_ctl
    import pm_sci_pkg::*;
#(
    parameter int                ADDR_W    = 6,
    parameter logic [ADDR_W-1:0] BASE_IDX  = 6'h10,
    parameter logic [ADDR_W-1:0] ACPI_IDX  = 6'h11,
    parameter logic [ADDR_W-1:0] PMCON_IDX = 6'h28,
    parameter logic [31:0]       BASE_MASK = 32'h0000_FF80,
    parameter logic [31:0]       BASE_RST  = 32'h0000_0001,
    parameter logic [7:0]        ACPI_RST  = 8'h00,
    parameter int                EN_BIT    = 7
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic [ADDR_W-1:0] cfg_idx,
    input  logic [3:0]        cfg_be,
    input  logic [31:0]       cfg_wdata,
    input  logic              sci_req,
    output logic [31:0]       pm_base,
    output logic [IRQ_W-1:0]  sci_irq,
    output logic              sci_level,
    output logic              sci_apic,
    output logic              sel_err,
    output logic [15:0]       pm_ctl,
    output logic [15:0]       pm_ctl_wmask,
    output logic              smi_en_wmask0
);
    localparam sel_t RST_SEL = sel_decode(ACPI_RST[CODE_W-1:0]);

    typedef struct packed {
        logic [31:0] base;
        logic [7:0]  acpi;
    } cfg_t;

    cfg_t cfg_d, cfg_q;
    logic hit_base, hit_acpi, eval;
    logic new_legal;
    logic [IRQ_W-1:0] new_irq;

    always_comb begin
        hit_base = cfg_we && (cfg_idx == BASE_IDX) && (|cfg_be);
        hit_acpi = cfg_we && (cfg_idx == ACPI_IDX) && cfg_be[0];
        eval     = hit_base || hit_acpi;
        cfg_d    = cfg_q;
        if (hit_base) begin
            for (int b = 0; b < 4; b++) begin
                if (cfg_be[b]) cfg_d.base[b*8 +: 8] = cfg_wdata[b*8 +: 8];
            end
        end
        if (hit_acpi) cfg_d.acpi = cfg_wdata[7:0];
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg_q.base <= BASE_RST;
            cfg_q.acpi <= ACPI_RST;
        end else begin
            cfg_q <= cfg_d;
        end
    end

    pm_sci_decode u_dec (
        .code  (cfg_d.acpi[CODE_W-1:0]),
        .legal (new_legal),
        .irq   (new_irq)
    );

    pm_sci_router #(.RST_IRQ(RST_SEL.irq)) u_rt (
        .clk     (clk),
        .rst_n   (rst_n),
        .eval    (eval),
        .legal   (new_legal),
        .new_irq (new_irq),
        .sci_req (sci_req),
        .tgt     (sci_irq),
        .line    (sci_level),
        .err     (sel_err)
    );

    pm_sci_lock #(.CTL_W(16)) u_lk (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr      (cfg_we && (cfg_idx == PMCON_IDX)),
        .be      (cfg_be[1:0]),
        .wdata   (cfg_wdata[15:0]),
        .ctl     (pm_ctl),
        .wmask   (pm_ctl_wmask),
        .smi_wm0 (smi_en_wmask0)
    );

    assign pm_base  = cfg_q.acpi[EN_BIT] ? (cfg_q.base & BASE_MASK) : '0;
    assign sci_apic = (sci_irq >= IRQ_W'(APIC_LO));
endmodule

// File: rtl/pm_sci_ctl_chk.sv
module pm_sci_ctl_chk
    import pm_sci_pkg::*;
(
    input logic             clk,
    input logic             rst_n,
    input logic             sci_req,
    input logic [IRQ_W-1:0] sci_irq,
    input logic             sci_level,
    input logic [31:0]      pm_base,
    input logic             acpi_en,
    input logic [15:0]      pm_ctl,
    input logic             smi_en_wmask0
);
    // R1: target is always a legal IRQ
    a_r1_target_legal: assert property (@(posedge clk) disable iff (!rst_n)
        (sci_irq == 5'd9) || (sci_irq == 5'd10) || (sci_irq == 5'd11) ||
        (sci_irq == 5'd20) || (sci_irq == 5'd21));

    // R3: never retarget while the line was high
    a_r3_no_move_when_high: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(sci_irq) |-> !$past(sci_level));

    // R5: base is hidden while ACPI is disabled
    a_r5_base_gated: assert property (@(posedge clk) disable iff (!rst_n)
        !acpi_en |-> (pm_base == 32'd0));

    // R6: line high only after a high request
    a_r6_level_follows: assert property (@(posedge clk) disable iff (!rst_n)
        sci_level |-> $past(sci_req));

    // R7: lock bit is sticky
    a_r7_lock_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        $past(pm_ctl[LOCK_BIT]) |-> pm_ctl[LOCK_BIT]);

    // R8: SMI enable bit 0 mask stays cleared
    a_r8_smi_mask_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(smi_en_wmask0) |-> !smi_en_wmask0);
endmodule

bind pm_sci_ctl pm_sci_ctl_chk u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .sci_req       (sci_req),
    .sci_irq       (sci_irq),
    .sci_level     (sci_level),
    .pm_base       (pm_base),
    .acpi_en       (cfg_q.acpi[EN_BIT]),
    .pm_ctl        (pm_ctl),
    .smi_en_wmask0 (smi_en_wmask0)
);

// File: tb/pm_sci_ctl_test.sv
module pm_sci_ctl_test;
    localparam logic [5:0] BASE_IDX  = 6'h10;
    localparam logic [5:0] ACPI_IDX  = 6'h11;
    localparam logic [5:0] PMCON_IDX = 6'h28;

    logic        clk = 0;
    logic        rst_n = 0;
    logic        cfg_we = 0;
    logic [5:0]  cfg_idx = '0;
    logic [3:0]  cfg_be = '0;
    logic [31:0] cfg_wdata = '0;
    logic        sci_req = 0;
    logic [31:0] pm_base;
    logic [4:0]  sci_irq;
    logic        sci_level, sci_apic, sel_err, smi_en_wmask0;
    logic [15:0] pm_ctl, pm_ctl_wmask;

    int checks = 0;
    int failures = 0;
    bit done = 0;

    always #10 clk = ~clk;

    pm_sci_ctl uut (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_idx(cfg_idx),
        .cfg_be(cfg_be), .cfg_wdata(cfg_wdata), .sci_req(sci_req),
        .pm_base(pm_base), .sci_irq(sci_irq), .sci_level(sci_level),
        .sci_apic(sci_apic), .sel_err(sel_err), .pm_ctl(pm_ctl),
        .pm_ctl_wmask(pm_ctl_wmask), .smi_en_wmask0(smi_en_wmask0)
    );

    typedef struct {
        logic [4:0]  irq;
        logic        line;
        logic [31:0] base;
        logic        err;
        logic [15:0] ctl;
        string       tag;
    } exp_t;

    exp_t q[$];

    // monitor: compare one expected item per cycle
    always @(negedge clk) begin
        if (q.size() > 0) begin
            exp_t e;
            logic [15:0] ewm;
            e = q.pop_front();
            ewm = e.ctl[4] ? 16'hFFEF : 16'hFFFF;
            checks++;
            if (sci_irq !== e.irq || sci_level !== e.line || pm_base !== e.base ||
                sel_err !== e.err || pm_ctl !== e.ctl || pm_ctl_wmask !== ewm ||
                smi_en_wmask0 !== !e.ctl[4] || sci_apic !== (e.irq >= 5'd16)) begin
                failures++;
                $display("FAIL %s: irq=%0d line=%0b base=%h err=%0b ctl=%h wm=%h smi=%0b apic=%0b expected irq=%0d line=%0b base=%h err=%0b ctl=%h wm=%h smi=%0b apic=%0b",
                    e.tag, sci_irq, sci_level, pm_base, sel_err, pm_ctl, pm_ctl_wmask,
                    smi_en_wmask0, sci_apic, e.irq, e.line, e.base, e.err, e.ctl, ewm,
                    !e.ctl[4], (e.irq >= 5'd16));
            end
        end
    end

    task automatic step(input logic we, input logic [5:0] idx, input logic [3:0] be,
                        input logic [31:0] d, input logic req,
                        input logic [4:0] ei, input logic el, input logic [31:0] eb,
                        input logic ee, input logic [15:0] ec, input string tag);
        exp_t e;
        @(negedge clk);
        cfg_we = we; cfg_idx = idx; cfg_be = be; cfg_wdata = d; sci_req = req;
        @(posedge clk);
        #1;
        cfg_we = 0;
        e.irq = ei; e.line = el; e.base = eb; e.err = ee; e.ctl = ec; e.tag = tag;
        q.push_back(e);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 0; cfg_we = 0; sci_req = 0;
        repeat (2) @(posedge clk);
        @(negedge clk);
        rst_n = 1;
    endtask

    initial begin
        #4_000_000;
        if (!done) begin
            failures++;
            checks++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        do_reset();
        step(0, 0, 0, 0, 0, 9, 0, 0, 0, 16'h0, "R11 reset state");
        step(1, BASE_IDX, 4'hF, 32'h1F81, 0, 9, 0, 0, 0, 16'h0, "R5 base hidden while disabled");
        step(1, ACPI_IDX, 4'h1, 32'h81, 0, 10, 0, 32'h1F80, 0, 16'h0, "R1 code1 R5 enabled base");
        step(1, ACPI_IDX, 4'h1, 32'h82, 0, 11, 0, 32'h1F80, 0, 16'h0, "R1 code2");
        step(1, ACPI_IDX, 4'h1, 32'h84, 0, 20, 0, 32'h1F80, 0, 16'h0, "R1 code4 R10 apic");
        step(1, ACPI_IDX, 4'h1, 32'h85, 0, 21, 0, 32'h1F80, 0, 16'h0, "R1 code5 R10 apic");
        step(1, ACPI_IDX, 4'h1, 32'h83, 0, 21, 0, 32'h1F80, 1, 16'h0, "R2 reserved code3");
        step(0, 0, 0, 0, 0, 21, 0, 32'h1F80, 0, 16'h0, "R2 error is one pulse");
        step(1, ACPI_IDX, 4'h1, 32'h87, 0, 21, 0, 32'h1F80, 1, 16'h0, "R2 reserved code7");
        step(1, ACPI_IDX, 4'h1, 32'h80, 0, 9, 0, 32'h1F80, 0, 16'h0, "R1 code0 R4");
        step(1, BASE_IDX, 4'h2, 32'h0000_2300, 0, 9, 0, 32'h2380, 0, 16'h0, "R9 partial base byte");
        step(0, 0, 0, 0, 1, 9, 1, 32'h2380, 0, 16'h0, "R6 line rises");
        step(0, 0, 0, 0, 1, 9, 1, 32'h2380, 0, 16'h0, "R6 line holds");
        step(1, ACPI_IDX, 4'h1, 32'h84, 1, 9, 0, 32'h2380, 0, 16'h0, "R3 old pin released");
        step(0, 0, 0, 0, 1, 20, 1, 32'h2380, 0, 16'h0, "R3 new pin raised");
        step(1, ACPI_IDX, 4'h1, 32'h84, 1, 20, 1, 32'h2380, 0, 16'h0, "R3 same target no effect");
        step(1, ACPI_IDX, 4'h1, 32'h86, 1, 20, 1, 32'h2380, 1, 16'h0, "R2 reserved while high");
        step(0, 0, 0, 0, 0, 20, 0, 32'h2380, 0, 16'h0, "R6 line falls");
        step(1, ACPI_IDX, 4'h1, 32'h81, 0, 10, 0, 32'h2380, 0, 16'h0, "R4 direct retarget");
        step(1, ACPI_IDX, 4'hE, 32'h85, 0, 10, 0, 32'h2380, 0, 16'h0, "R9 be0 clear ignored");
        step(1, 6'h12, 4'hF, 32'h85, 0, 10, 0, 32'h2380, 0, 16'h0, "R9 other index ignored");
        step(1, ACPI_IDX, 4'h1, 32'h01, 0, 10, 0, 32'h0, 0, 16'h0, "R5 disable hides base");
        step(1, PMCON_IDX, 4'h3, 32'h0003, 0, 10, 0, 32'h0, 0, 16'h0003, "R7 unlocked write");
        step(1, PMCON_IDX, 4'h3, 32'h0013, 0, 10, 0, 32'h0, 0, 16'h0013, "R7 lock set R8");
        step(1, PMCON_IDX, 4'h3, 32'h0000, 0, 10, 0, 32'h0, 0, 16'h0010, "R7 lock sticky R8");
        step(1, PMCON_IDX, 4'h2, 32'hAB00, 0, 10, 0, 32'h0, 0, 16'hAB10, "R7 high byte only");
        step(0, 0, 0, 0, 0, 10, 0, 32'h0, 0, 16'hAB10, "R8 mask stays cleared");
        do_reset();
        step(0, 0, 0, 0, 0, 9, 0, 0, 0, 16'h0, "R11 reset releases lock");
        step(1, ACPI_IDX, 4'h1, 32'h80, 0, 9, 0, 32'h0, 0, 16'h0, "R11 base default masked");
        @(negedge clk);
        @(negedge clk);
        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule